// File: doc/BRIEF.md
# Display RAM Host Access Controller

This block is the parallel host port of a graphic LCD controller whose display memory is organized in pages. The host selects a page and a column with command writes. It then moves bytes into or out of display memory with data accesses. After every data access the column counter advances by one, so a run of bytes fills a page row by row. A column value past the last real column locks the counter until a new column is set. A ninth page holds a one-bit indicator row. A busy flag, readable through a status read, marks the cycles after each accepted access during which all other accesses are dropped.

A second, read-only port gives the display side the byte for a given segment and page. It applies the segment-direction mapping, which can be normal or mirrored.

Commands are written with `sel_data`=0 and `rd_nwr`=0, and `wr_byte` carries the code:
- 0x00–0x0F load the column's low nibble.
- 0x10–0x1F load its high nibble.
- 0xB0–0xBF load the page.
- 0xA0 selects normal segment direction and 0xA1 selects mirrored.

A status read is `sel_data`=0 with `rd_nwr`=1. Data accesses use `sel_data`=1.

Top module: `lcd_host_port`

## Requirements
- R1: After reset the column is 0, the page is 0, the segment direction is normal, the counter is unlocked, the busy flag is clear and `rd_byte` is 0x00.
- R2: A data write stores `wr_byte` at the current page and column. A data read returns that byte on `rd_byte` one clock after the access. Each data read or write then advances the column by one.
- R3: The column counter steps from column COLS-1 (131) back to column 0.
- R4: Setting the column to COLS (0x84) or above locks the counter. While it is locked, data writes store nothing, data reads return 0x00 and the column does not move.
- R5: Any new column nibble that yields a valid column releases the lock.
- R6: Page 8 is the indicator row. A write there keeps only bit 0. A read from it returns bits 7..1 as zero and bit 0 as stored.
- R7: A column step, including the wrap, never changes the page.
- R8: The display port returns the byte of RAM column s for segment s when the direction is normal (0xA0). It returns the byte of column COLS-1-s when the direction is mirrored (0xA1).
- R9: After each accepted command or data access, the busy flag is set for BUSY_CYC clocks. A status read returns it in bit 7 with bits 6..0 at zero. A status read itself does not start a busy period.
- R10: While busy, data accesses and command writes are ignored. Memory, column and page keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Access strobe, one access per cycle it is high |
| sel_data | input | 1 | 1 = display data, 0 = command or status |
| rd_nwr | input | 1 | 1 = read, 0 = write |
| wr_byte | input | 8 | Write data or command code |
| rd_byte | output | 8 | Read data or status, valid the cycle after a read |
| seg_idx | input | 8 | Segment index on the display port |
| seg_page | input | 4 | Page on the display port |
| seg_byte | output | 8 | RAM byte for that segment and page after direction mapping |

## Verification
Byte runs written at the start of a page, at the last column and in the indicator row distinguish plain addressing from the wrap and from the one-bit row. A write and a read with the column set to 0x84, followed by a read at column 0 after a new column setting, separate a locked counter from one that silently writes somewhere. Status reads on every clock after an access measure the exact busy length. A second write issued inside that window shows whether busy accesses are dropped without moving the column. Bytes placed at columns 0 and 131, probed through the display port in both directions, tell mirrored mapping from normal mapping.

// File: rtl/lcd_host_port.sv
module lcd_host_port #(
  parameter int COLS     = 132,
  parameter int PAGES    = 8,
  parameter int BUSY_CYC = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req,
  input  logic       sel_data,
  input  logic       rd_nwr,
  input  logic [7:0] wr_byte,
  output logic [7:0] rd_byte,
  input  logic [7:0] seg_idx,
  input  logic [3:0] seg_page,
  output logic [7:0] seg_byte
);
  localparam int DEPTH = PAGES * COLS;
  localparam int AW    = $clog2(DEPTH);
  localparam int CW    = $clog2(BUSY_CYC + 1);
  localparam logic [7:0] LAST = 8'(COLS - 1);
  localparam logic [3:0] IND  = 4'(PAGES);

  logic [7:0]    mem [DEPTH];
  logic [COLS-1:0] ind;
  logic [7:0]    col;
  logic [3:0]    page;
  logic          mirror, lock;
  logic [CW-1:0] bcnt;

  wire busy    = bcnt != '0;
  wire stat_rd = req & ~sel_data & rd_nwr;
  wire acc     = req & ~busy & ~stat_rd;
  wire d_wr    = acc & sel_data & ~rd_nwr;
  wire d_rd    = acc & sel_data & rd_nwr;
  wire c_wr    = acc & ~sel_data & ~rd_nwr;

  wire in_mem = !lock && page < IND;
  wire in_ind = !lock && page == IND;
  wire [AW-1:0] addr = AW'(page) * AW'(COLS) + AW'(col);

  wire [7:0] col_lo  = {col[7:4], wr_byte[3:0]};
  wire [7:0] col_hi  = {wr_byte[3:0], col[3:0]};
  wire       set_lo  = c_wr && wr_byte[7:4] == 4'h0;
  wire       set_hi  = c_wr && wr_byte[7:4] == 4'h1;
  wire [7:0] col_set = set_lo ? col_lo : col_hi;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col <= '0; page <= '0; mirror <= 1'b0; lock <= 1'b0;
      bcnt <= '0; rd_byte <= '0;
    end else begin
      if (acc) bcnt <= CW'(BUSY_CYC);
      else if (busy) bcnt <= bcnt - 1'b1;

      if (stat_rd) rd_byte <= {busy, 7'b0};

      if (set_lo || set_hi) begin
        col  <= col_set;
        lock <= col_set >= 8'(COLS);
      end else if (c_wr && wr_byte[7:4] == 4'hB) begin
        page <= wr_byte[3:0];
      end else if (c_wr && wr_byte[7:1] == 7'h50) begin
        mirror <= wr_byte[0];
      end

      if ((d_wr || d_rd) && !lock) col <= (col == LAST) ? 8'd0 : col + 8'd1;

      if (d_rd) begin
        if (in_mem)      rd_byte <= mem[addr];
        else if (in_ind) rd_byte <= {7'b0, ind[col]};
        else             rd_byte <= 8'h00;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (d_wr && in_mem) mem[addr] <= wr_byte;
    if (d_wr && in_ind) ind[col] <= wr_byte[0];
  end

  wire [7:0]    scol  = mirror ? LAST - seg_idx : seg_idx;
  wire          s_ok  = seg_idx < 8'(COLS);
  wire [AW-1:0] saddr = AW'(seg_page) * AW'(COLS) + AW'(scol);

  always_comb begin
    seg_byte = 8'h00;
    if (s_ok && seg_page < IND)       seg_byte = mem[saddr];
    else if (s_ok && seg_page == IND) seg_byte = {7'b0, ind[scol]};
  end

  assert_col_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !lock |-> col < 8'(COLS));
  assert_lock_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && (d_wr || d_rd)) |=> ($stable(col) && lock));
  assert_ind_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (d_rd && page == IND) |=> rd_byte[7:1] == 7'b0);
  assert_page_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (d_wr || d_rd) |=> $stable(page));
  assert_busy_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> busy);
  assert_status_fmt_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |=> rd_byte[6:0] == 7'b0);
  assert_busy_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req && !stat_rd) |=> ($stable(col) && $stable(page) && $stable(mirror)));
endmodule

// File: tb/tb_lcd_host_port.sv
module tb_lcd_host_port;
  localparam int B = 3;
  logic clk = 1'b0, rst_n = 1'b0, req = 1'b0, sel_data = 1'b0, rd_nwr = 1'b0;
  logic [7:0] wr_byte = '0, seg_idx = '0;
  logic [3:0] seg_page = '0;
  logic [7:0] rd_byte, seg_byte;
  int tests = 0, fails = 0;
  bit done = 0;

  lcd_host_port #(.COLS(132), .PAGES(8), .BUSY_CYC(B)) dut (
    .clk(clk), .rst_n(rst_n), .req(req), .sel_data(sel_data), .rd_nwr(rd_nwr),
    .wr_byte(wr_byte), .rd_byte(rd_byte), .seg_idx(seg_idx),
    .seg_page(seg_page), .seg_byte(seg_byte));

  always #2.5 clk = ~clk;

  task automatic check(string r, logic [7:0] act, logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", r, act, exp);
    end
  endtask

  task automatic access(logic d, logic r, logic [7:0] v, output logic [7:0] q);
    @(negedge clk); req = 1; sel_data = d; rd_nwr = r; wr_byte = v;
    @(negedge clk); req = 0; q = rd_byte;
    repeat (B) @(negedge clk);
  endtask
  task automatic cmd(logic [7:0] v); logic [7:0] q; access(0, 0, v, q); endtask
  task automatic wr(logic [7:0] v);  logic [7:0] q; access(1, 0, v, q); endtask
  task automatic rd(output logic [7:0] q); access(1, 1, 8'h00, q); endtask
  task automatic setcol(logic [7:0] c); cmd({4'h1, c[7:4]}); cmd({4'h0, c[3:0]}); endtask

  task automatic t_reset;
    logic [7:0] q;
    check("R1 rd_byte", rd_byte, 8'h00);
    access(0, 1, 8'h00, q);
    check("R1 status", q, 8'h00);
    wr(8'h5A);
    setcol(8'd1); wr(8'h00);
    setcol(8'd0); rd(q);
    check("R1 col/page 0", q, 8'h5A);
  endtask

  task automatic t_rw;
    logic [7:0] q;
    cmd(8'hB3); setcol(8'd40);
    for (int i = 0; i < 4; i++) wr(8'h20 + 8'(i * 17));
    setcol(8'd40);
    for (int i = 0; i < 4; i++) begin rd(q); check("R2 burst", q, 8'h20 + 8'(i * 17)); end
  endtask

  task automatic t_wrap;
    logic [7:0] q;
    cmd(8'hB3); setcol(8'd0); wr(8'h00);
    cmd(8'hB2); setcol(8'd131); wr(8'h77); wr(8'h88);
    setcol(8'd0); rd(q); check("R3 wrap to col 0", q, 8'h88);
    cmd(8'hB3); setcol(8'd0); rd(q); check("R7 next page untouched", q, 8'h00);
    cmd(8'hB2); setcol(8'd131); rd(q); check("R3 last col", q, 8'h77);
  endtask

  task automatic t_lock;
    logic [7:0] q;
    cmd(8'hB0); setcol(8'd0); wr(8'h12);
    setcol(8'h84); wr(8'hEE); rd(q);
    check("R4 locked read", q, 8'h00);
    cmd(8'h00); cmd(8'h10); rd(q);
    check("R5 released, R4 no write", q, 8'h12);
    rd(q); check("R5 counter runs", q, 8'h00);
  endtask

  task automatic t_ind;
    logic [7:0] q;
    cmd(8'hB8); setcol(8'd7); wr(8'hFE); wr(8'h01);
    setcol(8'd7); rd(q); check("R6 D0 only (FE)", q, 8'h00);
    rd(q); check("R6 D0 only (01)", q, 8'h01);
    seg_page = 4'd8; seg_idx = 8'd8; #1;
    check("R6 display row", seg_byte, 8'h01);
  endtask

  task automatic t_busy;
    logic [7:0] q;
    cmd(8'hB4); setcol(8'd20);
    @(negedge clk); req = 1; sel_data = 1; rd_nwr = 0; wr_byte = 8'h55;
    @(negedge clk); sel_data = 0; rd_nwr = 1;
    for (int k = 1; k <= B + 1; k++) begin
      @(negedge clk);
      check($sformatf("R9 status k=%0d", k), rd_byte, (k <= B) ? 8'h80 : 8'h00);
    end
    req = 0;
    @(negedge clk); req = 1; sel_data = 1; rd_nwr = 0; wr_byte = 8'h99;
    @(negedge clk); sel_data = 0; rd_nwr = 0; wr_byte = 8'hB5;
    @(negedge clk); sel_data = 1; wr_byte = 8'hAA;
    @(negedge clk); req = 0;
    repeat (B) @(negedge clk);
    wr(8'h66);
    setcol(8'd20); rd(q); check("R10 first byte kept", q, 8'h55);
    rd(q); check("R2 col 21", q, 8'h99);
    rd(q); check("R10 busy write and page cmd dropped", q, 8'h66);
  endtask

  task automatic t_adc;
    cmd(8'hB1); setcol(8'd0); wr(8'h3C);
    setcol(8'd131); wr(8'hC3);
    seg_page = 4'd1; seg_idx = 8'd0; #1;
    check("R8 normal seg0", seg_byte, 8'h3C);
    cmd(8'hA1);
    seg_idx = 8'd0; #1;   check("R8 mirror seg0", seg_byte, 8'hC3);
    seg_idx = 8'd131; #1; check("R8 mirror seg131", seg_byte, 8'h3C);
    cmd(8'hA0);
    seg_idx = 8'd131; #1; check("R8 normal seg131", seg_byte, 8'hC3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset(); t_rw(); t_wrap(); t_lock(); t_ind(); t_busy(); t_adc();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (20000) @(posedge clk); tests++; fails++; $display("FAIL watchdog expired"); end
    join_any
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule